// File: doc/BRIEF.md
# SPI Serial EEPROM Slave

This block answers on an SPI slave port the way a small serial EEPROM does. A host selects it with an active-low select line. On each transfer it clocks in an 8-bit instruction. For reads and writes, a 9-bit byte address follows. The top address bit travels inside the instruction byte and the low eight bits follow in a separate address byte. After the address come the data bytes. The 512-byte array is held in ordinary registers. Writes land in a page buffer first, and that buffer is copied into the array only when select is released on a clean byte boundary.

A simulated internal write cycle follows each committed write and lasts a parameterised number of system clocks. During that cycle only the status read is honoured. A write-enable latch must be set before any write is accepted, and it drops by itself once a write cycle has finished. A write-protect input and a hold input complete the pin set. All serial pins are synchronised into the system clock domain, so the system clock must run well above the serial clock. Both clock-idle-low mode (0,0) and clock-idle-high mode (1,1) work without configuration, because input is sampled on rising serial-clock edges and output changes on falling ones.

Top module: `spi_ee_slave`

## Requirements
- R1: After reset the write-enable latch is clear, `so_oe` is low, and every array or status write is refused until the enable instruction 0x06 has been received.
- R2: After reset the block accepts no instruction until it sees a falling edge on `cs_n`, even if `cs_n` was already low when reset ended.
- R3: Instruction bytes: read is 0000_A011 and write is 0000_A010, where bit 3 (A) is address bit 8. Enable is 0x06, disable is 0x04, status read is 0x05 and status write is 0x01.
- R4: A read takes the low address byte MSB first and then returns data MSB first, with each bit changing after a falling serial-clock edge. The address increments across the whole array for as long as clocks continue.
- R5: A write sends data bytes MSB first after the address. Each byte goes to the next column of the 16-byte page, and the column wraps within that page.
- R6: A write commits only if `cs_n` rises after a whole, nonzero number of data bytes. If `cs_n` rises mid-byte, the array, the write cycle and the enable latch are all left unchanged.
- R7: The enable latch clears when a write cycle finishes. The disable instruction also clears it.
- R8: A committed write sets write-in-progress for WR_CYCLES system clocks. While it is set, every instruction except status read is ignored and SO stays undriven.
- R9: After an unrecognised instruction, nothing more is shifted in and SO stays undriven until the next falling edge of `cs_n`.
- R10: `so_oe` is high only while read data or status data is being shifted out.
- R11: Driving `hold_n` low while the serial clock is low pauses the transfer and releases SO. Serial-clock edges during the hold are ignored, and the transfer resumes at the same bit.
- R12: While `wp_n` is low, no array or status write commits.
- R13: Modes (0,0) and (1,1) both work for reads and writes.
- R14: Status byte layout: bit 0 is write-in-progress, bit 1 is the enable latch, and bits 7:2 hold the value last written by status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low transfer pause |
| wp_n | input | 1 | Active-low write protect |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for SO; SO is high-impedance when low |

## Verification
The assertions check on every cycle that SO is driven only in the two output phases and never during a hold or after a rejected instruction. They also check that a write starts only with the enable latch set, protect released, no cycle running and the bit counter on a byte boundary, and that a finished cycle clears the enable latch. Array contents, page wrap, the A8 bit carried in the instruction, hold resumption, mode (1,1) and the reset-while-selected case can only be shown by the bench's scenarios, which read the data back through the serial port.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_RDATA, ST_WDATA, ST_RDSR, ST_WRSR, ST_SKIP
  } ee_state_t;

  typedef enum logic [2:0] {
    C_NONE, C_READ, C_WRITE, C_WREN, C_WRDI, C_RDSR, C_WRSR
  } ee_cmd_t;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;

  // Bit 3 of read/write instructions carries address bit 8.
  function automatic ee_cmd_t decode_op(input logic [7:0] op);
    ee_cmd_t c;
    c = C_NONE;
    if (op[7:4] == 4'h0 && op[2:0] == 3'b011)      c = C_READ;
    else if (op[7:4] == 4'h0 && op[2:0] == 3'b010) c = C_WRITE;
    else begin
      case (op)
        OP_WREN: c = C_WREN;
        OP_WRDI: c = C_WRDI;
        OP_RDSR: c = C_RDSR;
        OP_WRSR: c = C_WRSR;
        default: c = C_NONE;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/spi_ee_front.sv
module spi_ee_front #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic cs_fall,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s,
  output logic hold_act,
  output logic wp_ok
);
  // packed order {wp_n, hold_n, si, sck, cs_n}
  localparam logic [4:0] IDLE_V = 5'b11001;

  logic [4:0]    sq [SYNC];
  logic [4:0]    s;
  logic [SYNC:0] prime;
  logic          live, cs_p, sck_p, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) sq[i] <= IDLE_V;
      prime  <= '0;
      cs_p   <= 1'b1;
      sck_p  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      sq[0] <= {wp_n, hold_n, si, sck, cs_n};
      for (int i = 1; i < SYNC; i++) sq[i] <= sq[i-1];
      prime <= {prime[SYNC-1:0], 1'b1};
      cs_p  <= s[0];
      sck_p <= s[1];
      if (!s[1]) hold_q <= !s[3];   // hold only changes while the clock is low
    end
  end

  assign s        = sq[SYNC-1];
  assign live     = prime[SYNC];    // edges count only once the pipeline holds real pin values
  assign cs_fall  = live & cs_p & !s[0];
  assign cs_rise  = live & !cs_p & s[0];
  assign sck_rise = live & !sck_p & s[1] & !s[0] & !hold_q;
  assign sck_fall = live & sck_p & !s[1] & !s[0] & !hold_q;
  assign si_s     = s[2];
  assign hold_act = hold_q;
  assign wp_ok    = s[4];
endmodule

// File: rtl/spi_ee_wrtimer.sv
module spi_ee_wrtimer #(
  parameter int CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));
endmodule

// File: rtl/spi_ee_store.sv
module spi_ee_store #(
  parameter int DEPTH = 512,
  parameter int PAGE  = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [$clog2(DEPTH)-1:0]           rd_addr,
  output logic [7:0]                         rd_data,
  input  logic                               buf_we,
  input  logic [$clog2(PAGE)-1:0]            buf_col,
  input  logic [7:0]                         buf_data,
  input  logic                               buf_clr,
  input  logic                               commit,
  input  logic [$clog2(DEPTH)-$clog2(PAGE)-1:0] page_sel
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(PAGE);

  logic [7:0] mem  [DEPTH];
  logic [7:0] pbuf [PAGE];
  logic [PAGE-1:0] pmask;

  // one staging register and valid flag per page column
  for (genvar c = 0; c < PAGE; c++) begin : g_col
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pbuf[c]  <= '0;
        pmask[c] <= 1'b0;
      end else if (buf_clr) begin
        pmask[c] <= 1'b0;
      end else if (buf_we && buf_col == CW'(c)) begin
        pbuf[c]  <= buf_data;
        pmask[c] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else if (commit) begin
      for (int c = 0; c < PAGE; c++)
        if (pmask[c]) mem[{page_sel, CW'(c)}] <= pbuf[c];
    end
  end

  assign rd_data = mem[rd_addr];

  logic unused_aw;
  assign unused_aw = (AW == 0);
endmodule

// File: rtl/spi_ee_slave.sv
module spi_ee_slave
  import spi_ee_pkg::*;
#(
  parameter int MEM_BYTES   = 512,
  parameter int PAGE_BYTES  = 16,
  parameter int WR_CYCLES   = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  localparam int AW = $clog2(MEM_BYTES);   // at most 9: bit 8 rides in the instruction
  localparam int CW = $clog2(PAGE_BYTES);

  function automatic logic [AW-1:0] make_addr(input logic hi, input logic [7:0] lo);
    logic [8:0] f;
    f = {hi, lo};
    return f[AW-1:0];
  endfunction

  logic cs_fall, cs_rise, sck_rise, sck_fall, si_s, hold_act, wp_ok;
  logic busy, wr_done, wr_start, commit_arr, commit_sr;
  logic st_drive, at_bnd, in_skip, byte_end;

  ee_state_t     state;
  logic [7:0]    sh, out_sh, byte_in, rd_data, status_byte;
  logic [2:0]    bcnt;
  logic          is_wr, a_hi, got_q, so_q, so_en, wel_q;
  logic [AW-1:0] addr_q, rd_addr;
  logic [CW-1:0] col_q;
  logic [5:0]    sr_user, sr_new;
  ee_cmd_t       cmd_in;

  spi_ee_front #(.SYNC(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .wp_n(wp_n), .cs_fall(cs_fall), .cs_rise(cs_rise), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .si_s(si_s), .hold_act(hold_act), .wp_ok(wp_ok));

  spi_ee_wrtimer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(wr_start), .busy(busy), .done(wr_done));

  spi_ee_store #(.DEPTH(MEM_BYTES), .PAGE(PAGE_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .buf_we(state == ST_WDATA && byte_end), .buf_col(col_q), .buf_data(byte_in),
    .buf_clr(cs_fall), .commit(commit_arr), .page_sel(addr_q[AW-1:CW]));

  assign byte_in     = {sh[6:0], si_s};
  assign byte_end    = sck_rise && bcnt == 3'd7;
  assign cmd_in      = decode_op(byte_in);
  assign status_byte = {sr_user, wel_q, busy};
  assign rd_addr     = (state == ST_ADDR) ? make_addr(a_hi, byte_in) : addr_q + 1'b1;
  assign at_bnd      = (bcnt == 3'd0) && got_q;
  assign commit_arr  = cs_rise && state == ST_WDATA && at_bnd && wel_q && wp_ok && !busy;
  assign commit_sr   = cs_rise && state == ST_WRSR  && at_bnd && wel_q && wp_ok && !busy;
  assign wr_start    = commit_arr || commit_sr;
  assign st_drive    = (state == ST_RDATA) || (state == ST_RDSR);
  assign in_skip     = (state == ST_SKIP);
  assign so          = so_q;
  assign so_oe       = so_en && !hold_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;  sh <= '0;  out_sh <= '0;  bcnt <= '0;
      is_wr <= 1'b0;  a_hi <= 1'b0;  got_q <= 1'b0;  so_q <= 1'b0;  so_en <= 1'b0;
      wel_q <= 1'b0;  addr_q <= '0;  col_q <= '0;  sr_user <= '0;  sr_new <= '0;
    end else begin
      if (cs_rise) begin
        state <= ST_IDLE;
        so_en <= 1'b0;
        if (commit_sr) sr_user <= sr_new;
      end else if (cs_fall) begin
        state <= ST_OPC;
        bcnt  <= '0;
        got_q <= 1'b0;
        so_en <= 1'b0;
      end else begin
        case (state)
          ST_OPC: if (sck_rise) begin
            sh   <= byte_in;
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              if (busy && cmd_in != C_RDSR) state <= ST_SKIP;
              else begin
                case (cmd_in)
                  C_READ:  begin state <= ST_ADDR; is_wr <= 1'b0; a_hi <= byte_in[3]; end
                  C_WRITE: begin state <= ST_ADDR; is_wr <= 1'b1; a_hi <= byte_in[3]; end
                  C_WREN:  begin state <= ST_SKIP; wel_q <= 1'b1; end
                  C_WRDI:  begin state <= ST_SKIP; wel_q <= 1'b0; end
                  C_RDSR:  begin state <= ST_RDSR; out_sh <= status_byte; end
                  C_WRSR:  state <= ST_WRSR;
                  default: state <= ST_SKIP;
                endcase
              end
            end
          end
          ST_ADDR: if (sck_rise) begin
            sh   <= byte_in;
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              addr_q <= rd_addr;
              col_q  <= rd_addr[CW-1:0];
              out_sh <= rd_data;
              state  <= is_wr ? ST_WDATA : ST_RDATA;
            end
          end
          ST_RDATA, ST_RDSR: if (sck_fall) begin
            so_q  <= out_sh[7];
            so_en <= 1'b1;
            bcnt  <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              if (state == ST_RDATA) begin
                addr_q <= addr_q + 1'b1;
                out_sh <= rd_data;
              end else out_sh <= status_byte;
            end else out_sh <= {out_sh[6:0], 1'b0};
          end
          ST_WDATA: if (sck_rise) begin
            sh   <= byte_in;
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              got_q <= 1'b1;
              col_q <= col_q + 1'b1;     // wraps inside the page
            end
          end
          ST_WRSR: if (sck_rise) begin
            sh   <= byte_in;
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7 && !got_q) begin
              sr_new <= byte_in[7:2];
              got_q  <= 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (wr_done) wel_q <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_ee_slave_chk.sv
module spi_ee_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic so_oe,
  input logic st_drive,
  input logic hold_act,
  input logic wr_start,
  input logic wel,
  input logic wp_ok,
  input logic busy,
  input logic wr_done,
  input logic at_bnd,
  input logic in_skip
);
  // R10
  so_drive_chk: assert property (@(posedge clk) disable iff (!rst_n) so_oe |-> st_drive);
  // R11
  hold_float_chk: assert property (@(posedge clk) disable iff (!rst_n) hold_act |-> !so_oe);
  // R9
  skip_float_chk: assert property (@(posedge clk) disable iff (!rst_n) in_skip |-> !so_oe);
  // R12
  wp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_start |-> wp_ok);
  // R1
  wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_start |-> wel);
  // R6
  byte_bnd_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_start |-> at_bnd);
  // R8
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !wr_start);
  // R8
  wip_set_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_start |=> busy);
  // R7
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_done |=> !wel);
endmodule

bind spi_ee_slave spi_ee_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .so_oe(so_oe), .st_drive(st_drive), .hold_act(hold_act),
  .wr_start(wr_start), .wel(wel_q), .wp_ok(wp_ok), .busy(busy), .wr_done(wr_done),
  .at_bnd(at_bnd), .in_skip(in_skip));

// File: tb/spi_ee_slave_bench.sv
module spi_ee_slave_bench;
  localparam int WRC  = 1500;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b0, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic so, so_oe;
  logic mode3 = 1'b0;
  logic cap = 1'b0;
  int   nchk = 0, nerr = 0;

  logic [7:0] exp_v [$];
  string      exp_t [$];
  logic [7:0] mon_sh = '0;
  int         mon_n = 0;
  logic       mon_oe = 1'b1;

  always #2 clk = ~clk;   // 250 MHz

  spi_ee_slave #(.WR_CYCLES(WRC)) u_spi_ee_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe));

  task automatic report();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // scoreboard monitor: one compare per eight captured bits
  always @(posedge sck) begin
    if (cap) begin
      mon_sh = {mon_sh[6:0], so};
      mon_oe = mon_oe & so_oe;
      mon_n++;
      if (mon_n == 8) begin
        if (exp_v.size() == 0) chk(1'b0, "queue", mon_sh, 8'h00);
        else begin
          logic [7:0] e;
          string t;
          e = exp_v.pop_front();
          t = exp_t.pop_front();
          chk(mon_oe && (mon_sh === e), t, mon_sh, e);
        end
        mon_n  = 0;
        mon_oe = 1'b1;
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_lo();
    sck = mode3; tick(4); cs_n = 1'b0; tick(6);
  endtask

  task automatic cs_hi();
    tick(6); cs_n = 1'b1; tick(8);
  endtask

  task automatic bit_out(input logic b);
    if (mode3) begin
      sck = 1'b0; si = b; tick(HALF); sck = 1'b1; tick(HALF);
    end else begin
      si = b; tick(HALF); sck = 1'b1; tick(HALF); sck = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
  endtask

  task automatic expect_rd(input logic [7:0] e, input string tag);
    exp_v.push_back(e);
    exp_t.push_back(tag);
    cap = 1'b1; send(8'h00); cap = 1'b0;
  endtask

  task automatic float_byte(input string tag);
    for (int i = 0; i < 8; i++) begin
      bit_out(1'b0);
      chk(!so_oe, tag, {7'd0, so_oe}, 8'h00);
    end
  endtask

  task automatic rdsr(input logic [7:0] e, input string tag);
    cs_lo(); send(8'h05); expect_rd(e, tag); cs_hi();
  endtask

  task automatic cmd(input logic [7:0] op);
    cs_lo(); send(op); cs_hi();
  endtask

  task automatic wr(input logic [7:0] op, input logic [7:0] a, input int n,
                    input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2, input logic [7:0] d3);
    cs_lo(); send(op); send(a);
    if (n > 0) send(d0);
    if (n > 1) send(d1);
    if (n > 2) send(d2);
    if (n > 3) send(d3);
    cs_hi();
  endtask

  task automatic rd(input logic [7:0] op, input logic [7:0] a, input int n,
                    input logic [7:0] e0, input logic [7:0] e1, input logic [7:0] e2, input string tag);
    cs_lo(); send(op); send(a);
    if (n > 0) expect_rd(e0, tag);
    if (n > 1) expect_rd(e1, tag);
    if (n > 2) expect_rd(e2, tag);
    cs_hi();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    // R2: reset released with select already low; no edge means no instruction
    tick(10); rst_n = 1'b1; tick(10);
    chk(!so_oe, "R1", {7'd0, so_oe}, 8'h00);
    send(8'h05);
    float_byte("R2");
    cs_n = 1'b1; tick(10);

    // R1/R14: latch clear, writes refused without enable
    rdsr(8'h00, "R1");
    wr(8'h02, 8'h10, 1, 8'h55, 0, 0, 0); tick(WRC + 100);
    rd(8'h03, 8'h10, 1, 8'h00, 0, 0, "R1");
    cmd(8'h06);
    rdsr(8'h02, "R14");

    // R3/R5/R8/R7/R4: 3-byte write at 0x1F0 using A8 in the instruction
    wr(8'h0A, 8'hF0, 3, 8'hA1, 8'hB2, 8'hC3, 0);
    rdsr(8'h03, "R8");
    tick(WRC + 100);
    rdsr(8'h00, "R7");
    rd(8'h0B, 8'hF0, 3, 8'hA1, 8'hB2, 8'hC3, "R4");
    rd(8'h03, 8'hF0, 1, 8'h00, 0, 0, "R3");

    // R5: page wrap 0x02E,0x02F,0x020,0x021 ; R4: read crosses page
    cmd(8'h06);
    wr(8'h02, 8'h2E, 4, 8'h11, 8'h22, 8'h33, 8'h44); tick(WRC + 100);
    rd(8'h03, 8'h20, 2, 8'h33, 8'h44, 0, "R5");
    rd(8'h03, 8'h2F, 2, 8'h22, 8'h00, 0, "R4");

    // R6: select rises three bits into a data byte
    cmd(8'h06);
    cs_lo(); send(8'h02); send(8'h40); send(8'h99);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    cs_hi();
    rdsr(8'h02, "R6");
    rd(8'h03, 8'h40, 1, 8'h00, 0, 0, "R6");

    // R8: read attempt during a write cycle stays undriven
    wr(8'h02, 8'h50, 1, 8'h77, 0, 0, 0);
    cs_lo(); send(8'h03); float_byte("R8"); float_byte("R8"); cs_hi();
    rdsr(8'h03, "R8");
    tick(WRC + 100);
    rd(8'h03, 8'h50, 1, 8'h77, 0, 0, "R8");

    // R9: unknown instruction then a normal one
    cs_lo(); send(8'hFF); float_byte("R9"); float_byte("R9"); cs_hi();
    rdsr(8'h00, "R9");

    // R7: disable instruction
    cmd(8'h06); cmd(8'h04);
    rdsr(8'h00, "R7");

    // R12: write protect
    cmd(8'h06);
    wp_n = 1'b0;
    wr(8'h02, 8'h70, 1, 8'hAA, 0, 0, 0);
    rdsr(8'h02, "R12");
    wp_n = 1'b1;
    rd(8'h03, 8'h70, 1, 8'h00, 0, 0, "R12");

    // R14: status write of 0xFC
    cs_lo(); send(8'h01); send(8'hFC); cs_hi();
    rdsr(8'hFF, "R14");
    tick(WRC + 100);
    rdsr(8'hFC, "R14");

    // R11: hold in the middle of a read byte (0x1F0 holds A1)
    exp_v.push_back(8'hA1); exp_t.push_back("R11");
    cs_lo(); send(8'h0B); send(8'hF0);
    cap = 1'b1;
    bit_out(1'b1); bit_out(1'b1); bit_out(1'b1);
    cap = 1'b0;
    hold_n = 1'b0; tick(8);
    chk(!so_oe, "R11", {7'd0, so_oe}, 8'h00);
    sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
    chk(!so_oe, "R11", {7'd0, so_oe}, 8'h00);
    hold_n = 1'b1; tick(8);
    cap = 1'b1;
    for (int i = 0; i < 5; i++) bit_out(1'b0);
    cap = 1'b0;
    cs_hi();

    // R13: clock idles high
    mode3 = 1'b1; sck = 1'b1; tick(10);
    cmd(8'h06);
    wr(8'h0A, 8'h00, 1, 8'h5A, 0, 0, 0); tick(WRC + 100);
    rd(8'h0B, 8'h00, 1, 8'h5A, 0, 0, "R13");
    rdsr(8'hFC, "R13");
    mode3 = 1'b0; sck = 1'b0; tick(10);

    chk(exp_v.size() == 0, "queue", 8'(exp_v.size()), 8'h00);
    report();
  end
endmodule